// File: doc/BRIEF.md
# PCIe Configuration Access Filter

This block sits between a register-access master and the memory-mapped configuration window of a PCIe root port. Each request carries a bus, device, function, register offset, access size, direction and right-aligned write data. The block turns it into a window byte offset, byte enables and lane-positioned write data. It then presents one transaction to the window and waits for the window to complete it. Read data from the window is shifted back to bit 0 and masked to the access size before it returns to the master.

The window on the secondary bus repeats a single device at every device number, so the block lets only device 0 through on that bus. It learns which bus is the secondary one by snooping completed writes to the root port's own bus-number registers. Requests that are filtered out, misaligned or of an unknown size never reach the window. The master gets a one-cycle completion with the error flag raised, and a refused access returns all ones as read data.

Top module: `pcie_cfg_filter`

## Requirements
- R1: The window offset is {(bus − ROOT_BUS) mod 256 in bits [27:20], device in [19:15], function in [14:12], register offset in [11:0]}.
- R2: A request whose bus equals the recorded secondary bus and whose device is nonzero is refused. It never raises win_valid, and it completes with rsp_done and rsp_err high in the cycle after acceptance.
- R3: A refused request returns rsp_rdata = 0xFFFFFFFF. rsp_err is only ever high together with rsp_done, and an accepted access completes with rsp_err low.
- R4: After reset the recorded secondary bus is SEC_INIT (0xFF by default). Until a bus-number write is seen, only bus 0xFF has nonzero devices refused.
- R5: The secondary bus is updated only by a write that the window completes to bus ROOT_BUS, device 0, function 0. Reads, refused writes and writes to other devices or functions leave it unchanged.
- R6: A completed write at register offset 0x19 sets the secondary bus to write data bits [7:0] plus ROOT_BUS, modulo 256.
- R7: A completed write at offset 0x18 of size 2 or 4 sets the secondary bus to write data bits [15:8] plus ROOT_BUS, modulo 256. A 1-byte write at 0x18 leaves it unchanged.
- R8: req_size encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Byte enable i is set for each lane i in [offset[1:0], offset[1:0] + size). win_wdata is req_wdata shifted left by 8·offset[1:0]. rsp_rdata of a read is win_rdata shifted right by 8·offset[1:0] and masked to the size. rsp_rdata of a completed write is 0.
- R9: A 2-byte access with offset[0] set, a 4-byte access with offset[1:0] nonzero, and req_size = 3 are all refused in the same way as R2.
- R10: win_valid stays high with stable fields until win_done. rsp_done pulses for one cycle in the cycle after win_done. req_ready is low while a window transaction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_func | input | 3 | Target function number |
| req_reg | input | 12 | Register byte offset |
| req_size | input | 2 | Access size code (R8) |
| req_wdata | input | 32 | Right-aligned write data |
| win_valid | output | 1 | Window transaction outstanding |
| win_write | output | 1 | Window transaction direction |
| win_addr | output | 28 | Window byte offset |
| win_be | output | 4 | Window byte enables |
| win_wdata | output | 32 | Lane-positioned write data |
| win_done | input | 1 | Window completes the outstanding transaction |
| win_rdata | input | 32 | Window read data, valid with win_done |
| rsp_done | output | 1 | One-cycle completion pulse to the master |
| rsp_err | output | 1 | Request refused, valid with rsp_done |
| rsp_rdata | output | 32 | Right-aligned read data, valid with rsp_done |

## Verification
The assertions assume that the window raises win_done only while win_valid is high, and that req_valid is sampled only in cycles where req_ready is high. The directed tasks drive a request for one cycle from an idle block and answer the window exactly once per transaction, sometimes after several wait cycles. The bench never touches bus 0xFF before enumeration except to probe R4. The secondary bus is observed only through the accept or refuse outcome of probe accesses on the buses that a write should or should not have selected.

// File: rtl/cfgf_pkg.sv
// Package: shared widths, size codes, snooped register offsets and the
// request record passed between the filter's sub-blocks.
package cfgf_pkg;
    localparam int BUS_W  = 8;
    localparam int DEV_W  = 5;
    localparam int FN_W   = 3;
    localparam int REG_W  = 12;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;
    localparam int LANE_W = $clog2(BE_W);
    localparam int ADDR_W = BUS_W + DEV_W + FN_W + REG_W;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    localparam logic [REG_W-1:0] PRI_BUS_OFF = 12'h018;
    localparam logic [REG_W-1:0] SEC_BUS_OFF = 12'h019;

    typedef struct packed {
        logic              wr;
        logic [BUS_W-1:0]  bus;
        logic [DEV_W-1:0]  dev;
        logic [FN_W-1:0]   func;
        logic [REG_W-1:0]  regoff;
        logic [1:0]        size;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;
endpackage

// File: rtl/cfgf_decode.sv
// Decode: purely combinational. Forms the window offset, byte enables and
// lane-positioned write data of the incoming request, and decides whether
// the request must be refused (filtered device, misaligned or bad size).
// Assumes sec_bus is the currently recorded secondary bus number.
module cfgf_decode
    import cfgf_pkg::*;
#(
    parameter logic [BUS_W-1:0] ROOT_BUS = '0
) (
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FN_W-1:0]   func,
    input  logic [REG_W-1:0]  regoff,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [BUS_W-1:0]  sec_bus,
    output logic [ADDR_W-1:0] addr,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] lane_wdata,
    output logic              reject
);
    logic [BUS_W-1:0]  rel_bus;
    logic [LANE_W-1:0] lane_off;
    logic [LANE_W:0]   nbytes;
    logic [LANE_W:0]   lane_end;
    logic              misaligned;
    logic              filtered;

    // Offset fields: bus relative to the root port, then device, function, register.
    always_comb begin
        rel_bus  = bus - ROOT_BUS;
        addr     = {rel_bus, dev, func, regoff};
        lane_off = regoff[LANE_W-1:0];
    end

    // Size code to byte count and alignment check; unknown code counts as misaligned.
    always_comb begin
        nbytes     = '0;
        misaligned = 1'b0;
        case (size)
            SZ_BYTE: nbytes = (LANE_W+1)'(1);
            SZ_HALF: begin
                nbytes     = (LANE_W+1)'(2);
                misaligned = lane_off[0];
            end
            SZ_WORD: begin
                nbytes     = (LANE_W+1)'(4);
                misaligned = (lane_off != '0);
            end
            default: misaligned = 1'b1;
        endcase
        lane_end = {1'b0, lane_off} + nbytes;
    end

    // One enable per byte lane: lane inside [offset, offset + size).
    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        always_comb
            be[i] = !misaligned
                 && ((LANE_W+1)'(i) >= {1'b0, lane_off})
                 && ((LANE_W+1)'(i) < lane_end);
    end

    // Move right-aligned write data onto its byte lanes; decide refusal.
    always_comb begin
        lane_wdata = wdata << {lane_off, 3'b000};
        filtered   = (bus == sec_bus) && (dev != '0);
        reject     = misaligned || filtered;
    end
endmodule

// File: rtl/cfgf_secbus.sv
// Secondary-bus tracker: holds the recorded secondary bus number and updates
// it from completed writes to the root port's bus-number registers.
// Assumes commit pulses once per write the window has completed, with the
// request fields of that write held stable on the inputs.
module cfgf_secbus
    import cfgf_pkg::*;
#(
    parameter logic [BUS_W-1:0] ROOT_BUS = '0,
    parameter logic [BUS_W-1:0] SEC_INIT = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [BUS_W-1:0] bus,
    input  logic [DEV_W-1:0] dev,
    input  logic [FN_W-1:0]  func,
    input  logic [REG_W-1:0] regoff,
    input  logic [1:0]       size,
    input  logic [15:0]      wdata_lo,
    output logic [BUS_W-1:0] sec_bus
);
    logic             own_fn;
    logic             hit_sec;
    logic             hit_pri;
    logic [BUS_W-1:0] field;

    // Classify the committed write: root port function, which bus-number register.
    always_comb begin
        own_fn  = (bus == ROOT_BUS) && (dev == '0) && (func == '0);
        hit_sec = (regoff == SEC_BUS_OFF);
        hit_pri = (regoff == PRI_BUS_OFF) && (size != SZ_BYTE);
        field   = hit_sec ? wdata_lo[7:0] : wdata_lo[15:8];
    end

    // Record the new secondary bus, offset by the root port's bus number.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_bus <= SEC_INIT;
        else if (commit && own_fn && (hit_sec || hit_pri))
            sec_bus <= field + ROOT_BUS;
    end

    // R5
    sec_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sec_bus) |-> $past(commit));
endmodule

// File: rtl/cfgf_ctrl.sv
// Control: accepts one request at a time. Refused requests complete at once
// with an error; others are held on the window until it reports completion,
// after which read data is realigned and a one-cycle done pulse is given.
// Assumes win_done is only raised while win_valid is high.
module cfgf_ctrl
    import cfgf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  cfg_req_t          req,
    input  logic              reject,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] lane_wdata,
    input  logic              win_done,
    input  logic [DATA_W-1:0] win_rdata,
    output logic              req_ready,
    output logic              win_valid,
    output logic              win_write,
    output logic [ADDR_W-1:0] win_addr,
    output logic [BE_W-1:0]   win_be,
    output logic [DATA_W-1:0] win_wdata,
    output logic              commit,
    output cfg_req_t          held,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rdata
);
    typedef enum logic {ST_IDLE, ST_WAIT} ctrl_state_e;

    ctrl_state_e       state;
    logic [DATA_W-1:0] rd_shift;
    logic [DATA_W-1:0] rd_mask;
    logic [DATA_W-1:0] rd_aligned;

    // Handshake outputs derived from the state.
    always_comb begin
        req_ready = (state == ST_IDLE);
        commit    = (state == ST_WAIT) && win_done && held.wr;
    end

    // Bring window read data back to bit 0 and keep only the accessed bytes.
    always_comb begin
        rd_shift = win_rdata >> {held.regoff[LANE_W-1:0], 3'b000};
        case (held.size)
            SZ_BYTE: rd_mask = DATA_W'(8'hFF);
            SZ_HALF: rd_mask = DATA_W'(16'hFFFF);
            default: rd_mask = '1;
        endcase
        rd_aligned = rd_shift & rd_mask;
    end

    // Request sequencing, window drive and completion reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            held      <= '0;
            win_valid <= 1'b0;
            win_write <= 1'b0;
            win_addr  <= '0;
            win_be    <= '0;
            win_wdata <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
            rdata     <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        held <= req;
                        if (reject) begin
                            done  <= 1'b1;
                            err   <= 1'b1;
                            rdata <= '1;
                        end else begin
                            win_valid <= 1'b1;
                            win_write <= req.wr;
                            win_addr  <= addr;
                            win_be    <= be;
                            win_wdata <= lane_wdata;
                            state     <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (win_done) begin
                        win_valid <= 1'b0;
                        done      <= 1'b1;
                        rdata     <= held.wr ? '0 : rd_aligned;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10
    win_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid && !win_done |=> win_valid && $stable(win_addr) && $stable(win_be));
    // R3
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !win_valid && req_ready);
    // R3
    refused_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && err |-> rdata == '1);
endmodule

// File: rtl/pcie_cfg_filter.sv
// Top: configuration access filter in front of a root port's memory-mapped
// configuration window. Wires the decoder, the controller and the
// secondary-bus tracker. Assumes one request at a time, offered only while
// req_ready is high, and a window that answers each transaction once.
module pcie_cfg_filter
    import cfgf_pkg::*;
#(
    parameter logic [BUS_W-1:0] ROOT_BUS = 8'h00,
    parameter logic [BUS_W-1:0] SEC_INIT = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_bus,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [FN_W-1:0]   req_func,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [1:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              win_valid,
    output logic              win_write,
    output logic [ADDR_W-1:0] win_addr,
    output logic [BE_W-1:0]   win_be,
    output logic [DATA_W-1:0] win_wdata,
    input  logic              win_done,
    input  logic [DATA_W-1:0] win_rdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    cfg_req_t          req_in;
    cfg_req_t          held;
    logic [BUS_W-1:0]  sec_bus;
    logic [ADDR_W-1:0] dec_addr;
    logic [BE_W-1:0]   dec_be;
    logic [DATA_W-1:0] dec_wdata;
    logic              dec_reject;
    logic              commit;
    logic [BUS_W-1:0]  win_abs_bus;

    // Gather the request ports into one record.
    always_comb begin
        req_in.wr     = req_write;
        req_in.bus    = req_bus;
        req_in.dev    = req_dev;
        req_in.func   = req_func;
        req_in.regoff = req_reg;
        req_in.size   = req_size;
        req_in.wdata  = req_wdata;
    end

    cfgf_decode #(.ROOT_BUS(ROOT_BUS)) u_decode (
        .bus        (req_bus),
        .dev        (req_dev),
        .func       (req_func),
        .regoff     (req_reg),
        .size       (req_size),
        .wdata      (req_wdata),
        .sec_bus    (sec_bus),
        .addr       (dec_addr),
        .be         (dec_be),
        .lane_wdata (dec_wdata),
        .reject     (dec_reject)
    );

    cfgf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req        (req_in),
        .reject     (dec_reject),
        .addr       (dec_addr),
        .be         (dec_be),
        .lane_wdata (dec_wdata),
        .win_done   (win_done),
        .win_rdata  (win_rdata),
        .req_ready  (req_ready),
        .win_valid  (win_valid),
        .win_write  (win_write),
        .win_addr   (win_addr),
        .win_be     (win_be),
        .win_wdata  (win_wdata),
        .commit     (commit),
        .held       (held),
        .done       (rsp_done),
        .err        (rsp_err),
        .rdata      (rsp_rdata)
    );

    cfgf_secbus #(.ROOT_BUS(ROOT_BUS), .SEC_INIT(SEC_INIT)) u_secbus (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit),
        .bus      (held.bus),
        .dev      (held.dev),
        .func     (held.func),
        .regoff   (held.regoff),
        .size     (held.size),
        .wdata_lo (held.wdata[15:0]),
        .sec_bus  (sec_bus)
    );

    // Absolute bus of the outstanding window access, rebuilt from the offset.
    always_comb win_abs_bus = win_addr[ADDR_W-1 -: BUS_W] + ROOT_BUS;

    // R2
    no_filtered_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> !((win_abs_bus == sec_bus) && (win_addr[REG_W+FN_W +: DEV_W] != '0)));
    // R8
    be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ($countones(win_be) == 1 || $countones(win_be) == 2
                       || $countones(win_be) == 4));
endmodule

// File: tb/tb_pcie_cfg_filter.sv
module tb_pcie_cfg_filter;
    localparam logic [7:0] ROOT = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [4:0]  req_dev = '0;
    logic [2:0]  req_func = '0;
    logic [11:0] req_reg = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        win_valid;
    logic        win_write;
    logic [27:0] win_addr;
    logic [3:0]  win_be;
    logic [31:0] win_wdata;
    logic        win_done = 1'b0;
    logic [31:0] win_rdata = '0;
    logic        rsp_done;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pcie_cfg_filter #(.ROOT_BUS(ROOT)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_dev(req_dev), .req_func(req_func),
        .req_reg(req_reg), .req_size(req_size), .req_wdata(req_wdata),
        .win_valid(win_valid), .win_write(win_write), .win_addr(win_addr),
        .win_be(win_be), .win_wdata(win_wdata), .win_done(win_done),
        .win_rdata(win_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // One request; refused ones must never reach the window, others are answered with rsp.
    task automatic access(input logic wr, input logic [7:0] bus, input logic [4:0] dev,
                          input logic [2:0] fn, input logic [11:0] rg, input logic [1:0] sz,
                          input logic [31:0] wd, input logic [31:0] rsp, input bit exp_rej,
                          input logic [3:0] exp_be, input logic [31:0] exp_wd,
                          input logic [31:0] exp_rd, input string tag);
        logic [27:0] exp_addr;
        logic [7:0]  rel;
        rel      = bus - ROOT;
        exp_addr = {rel, dev, fn, rg};
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bus = bus; req_dev = dev;
        req_func = fn; req_reg = rg; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_rej) begin
            chk(!win_valid, {tag, " no window"}, 32'(win_valid), 0);
            chk(rsp_done && rsp_err, {tag, " refused done+err"}, {rsp_done, rsp_err}, 2'b11);
            if (!wr) chk(rsp_rdata == 32'hFFFF_FFFF, {tag, " refused rdata"}, rsp_rdata, 32'hFFFF_FFFF);
        end else begin
            chk(win_valid && win_write == wr, {tag, " window issue"}, {win_valid, win_write}, {1'b1, wr});
            chk(win_addr == exp_addr, {tag, " offset"}, 32'(win_addr), 32'(exp_addr));
            chk(win_be == exp_be, {tag, " byte enables"}, 32'(win_be), 32'(exp_be));
            if (wr) chk(win_wdata == exp_wd, {tag, " lane data"}, win_wdata, exp_wd);
            win_rdata = rsp;
            win_done  = 1'b1;
            @(negedge clk);
            win_done = 1'b0;
            chk(rsp_done && !rsp_err, {tag, " completion"}, {rsp_done, rsp_err}, 2'b10);
            chk(rsp_rdata == exp_rd, {tag, " read data"}, rsp_rdata, exp_rd);
        end
    endtask

    task automatic probe(input logic [7:0] bus, input logic [4:0] dev, input bit exp_rej,
                         input string tag);
        access(1'b0, bus, dev, 3'd0, 12'h000, 2'd2, 32'h0, 32'h1234_5678, exp_rej,
               4'hF, 32'h0, 32'h1234_5678, tag);
    endtask

    task automatic wr_root(input logic [2:0] fn, input logic [4:0] dev, input logic [11:0] rg,
                           input logic [1:0] sz, input logic [31:0] wd, input logic [3:0] be,
                           input logic [31:0] lane, input string tag);
        access(1'b1, ROOT, dev, fn, rg, sz, wd, 32'h0, 1'b0, be, lane, 32'h0, tag);
    endtask

    task automatic t_reset;
        chk(req_ready && !win_valid && !rsp_done && !rsp_err, "R10 reset state",
            {req_ready, win_valid, rsp_done, rsp_err}, 4'b1000);
    endtask

    task automatic t_initial_filter;
        probe(8'hFF, 5'd3, 1'b1, "R4 R2 R3 bus FF filtered at reset");
        access(1'b0, 8'h12, 5'd3, 3'd2, 12'h040, 2'd2, 32'h0, 32'hDEAD_BEEF, 1'b0,
               4'hF, 32'h0, 32'hDEAD_BEEF, "R1 R4 word read other bus");
        access(1'b0, 8'h10, 5'd31, 3'd7, 12'hFFC, 2'd2, 32'h0, 32'h0BAD_F00D, 1'b0,
               4'hF, 32'h0, 32'h0BAD_F00D, "R1 root bus high fields");
    endtask

    task automatic t_lanes;
        access(1'b0, 8'h12, 5'd0, 3'd0, 12'h041, 2'd0, 32'h0, 32'hA1B2_C3D4, 1'b0,
               4'b0010, 32'h0, 32'h0000_00C3, "R8 byte read lane 1");
        access(1'b0, 8'h12, 5'd0, 3'd0, 12'h042, 2'd1, 32'h0, 32'hA1B2_C3D4, 1'b0,
               4'b1100, 32'h0, 32'h0000_A1B2, "R8 half read lane 2");
        access(1'b1, 8'h12, 5'd1, 3'd0, 12'h042, 2'd1, 32'h0000_1234, 32'h0, 1'b0,
               4'b1100, 32'h1234_0000, 32'h0, "R8 half write lane 2");
        access(1'b1, 8'h12, 5'd1, 3'd0, 12'h043, 2'd0, 32'h0000_0077, 32'h0, 1'b0,
               4'b1000, 32'h7700_0000, 32'h0, "R8 byte write lane 3");
    endtask

    task automatic t_misaligned;
        access(1'b0, 8'h12, 5'd0, 3'd0, 12'h041, 2'd1, 32'h0, 32'h0, 1'b1,
               4'h0, 32'h0, 32'h0, "R9 half at odd offset");
        access(1'b0, 8'h12, 5'd0, 3'd0, 12'h042, 2'd2, 32'h0, 32'h0, 1'b1,
               4'h0, 32'h0, 32'h0, "R9 word at offset 2");
        access(1'b0, 8'h12, 5'd0, 3'd0, 12'h040, 2'd3, 32'h0, 32'h0, 1'b1,
               4'h0, 32'h0, 32'h0, "R9 size code 3");
    endtask

    task automatic t_no_capture;
        wr_root(3'd0, 5'd1, 12'h019, 2'd0, 32'h05, 4'b0010, 32'h0000_0500, "R5 write other device");
        wr_root(3'd1, 5'd0, 12'h019, 2'd0, 32'h05, 4'b0010, 32'h0000_0500, "R5 write other function");
        access(1'b0, ROOT, 5'd0, 3'd0, 12'h019, 2'd0, 32'h0, 32'h0000_0500, 1'b0,
               4'b0010, 32'h0, 32'h05, "R5 read of register");
        probe(8'h15, 5'd2, 1'b0, "R5 bus 15 still open");
        probe(8'hFF, 5'd2, 1'b1, "R5 bus FF still filtered");
    endtask

    task automatic t_capture_sec;
        wr_root(3'd0, 5'd0, 12'h019, 2'd0, 32'h01, 4'b0010, 32'h0000_0100, "R6 write secondary reg");
        probe(8'h11, 5'd1, 1'b1, "R6 R2 bus 11 dev 1 filtered");
        access(1'b0, 8'h11, 5'd0, 3'd3, 12'h000, 2'd2, 32'h0, 32'hCAFE_0001, 1'b0,
               4'hF, 32'h0, 32'hCAFE_0001, "R2 R1 bus 11 dev 0 open");
        probe(8'hFF, 5'd3, 1'b0, "R6 bus FF released");
    endtask

    task automatic t_capture_pri;
        wr_root(3'd0, 5'd0, 12'h018, 2'd0, 32'h0000_0300, 4'b0001, 32'h0000_0300, "R7 byte write primary");
        probe(8'h11, 5'd1, 1'b1, "R7 byte write no update");
        probe(8'h13, 5'd1, 1'b0, "R7 bus 13 not selected");
        wr_root(3'd0, 5'd0, 12'h018, 2'd1, 32'h0000_0400, 4'b0011, 32'h0000_0400, "R7 half write primary");
        probe(8'h14, 5'd2, 1'b1, "R7 half write selects 14");
        probe(8'h11, 5'd2, 1'b0, "R7 bus 11 released");
        wr_root(3'd0, 5'd0, 12'h018, 2'd2, 32'h00FF_0210, 4'hF, 32'h00FF_0210, "R7 word write primary");
        probe(8'h12, 5'd1, 1'b1, "R7 word write selects 12");
        access(1'b1, ROOT, 5'd0, 3'd0, 12'h019, 2'd1, 32'h0000_0030, 32'h0, 1'b1,
               4'h0, 32'h0, 32'h0, "R9 R5 misaligned secondary write");
        probe(8'h12, 5'd1, 1'b1, "R5 refused write no update");
        probe(8'h30, 5'd1, 1'b0, "R5 refused write bus 30 open");
    endtask

    task automatic t_wait_states;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_bus = 8'h40; req_dev = 5'd4;
        req_func = 3'd1; req_reg = 12'h008; req_size = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(win_valid && !req_ready && !rsp_done, "R10 held while waiting",
                {win_valid, req_ready, rsp_done}, 3'b100);
            @(negedge clk);
        end
        win_rdata = 32'h5555_AAAA;
        win_done  = 1'b1;
        @(negedge clk);
        win_done = 1'b0;
        chk(rsp_done && rsp_rdata == 32'h5555_AAAA, "R10 done after window",
            rsp_rdata, 32'h5555_AAAA);
        @(negedge clk);
        chk(!rsp_done && req_ready && !win_valid, "R10 done one cycle",
            {rsp_done, req_ready, win_valid}, 3'b010);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_initial_filter();
        t_lanes();
        t_misaligned();
        t_no_capture();
        t_capture_sec();
        t_capture_pri();
        t_wait_states();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end
endmodule